// File: doc/BRIEF.md
# Read-Strobe Gate Calibration Search Engine

This block finds, for several byte lanes at once, the delay at which the read-strobe gate should open. It asks for read bursts through a request/acknowledge handshake and takes one strobe-level sample per lane on every acknowledged burst. Each group of bursts is reduced to one level per lane: low, high, or uncertain (X). The levels are appended to a short history per lane. The delay grows one coarse tap per group. When the coarse range runs out, the read-enable latency moves up by one, starting two clocks before the expected strobe return.

A lane locks when its last nine levels read low, low, low, X, high, X, low, X, high, oldest first. That sequence marks the third strobe edge. A locked lane keeps its tap, latency and fine offset while the other lanes go on searching.

When a full pass over every latency and tap leaves any lane unlocked, the pass is repeated with a fine phase offset. The first offset is half a coarse tap, and each later retry halves it. The block reports failure after the pass run at an offset of one fine step. It reports done as soon as every lane is locked.

Top module: `dqs_gate_cal`

## Requirements
- R1: On an accepted start, the search begins with coarse tap 0, fine offset 0, and a read-enable latency of `exp_lat - 2` on every unlocked lane.
- R2: `burst_req` stays high for a whole group. A sample counts only in a cycle where `burst_ack` is high. A group ends after exactly 32 acknowledged bursts, and strobe values in cycles without acknowledge have no effect.
- R3: A lane's group is classified as low (code 00) or high (code 01) when all 32 samples equal the first one. It is classified as X (code 10) when any sample differs, including only the 32nd.
- R4: After each group the coarse tap of unlocked lanes rises by one. After tap NTAP-1 it returns to 0 and the latency rises by one, up to `exp_lat - 2 + NRDEN - 1`.
- R5: A lane locks when its nine-entry history equals 000X1X0X1, oldest first. X is satisfied only by a classified X. The lane keeps the tap, latency and fine offset of the group that completed the match.
- R6: Once locked, a lane's tap, latency and fine outputs and its `lock_mask` bit do not change until the next start, while the other lanes continue searching.
- R7: When a pass ends with any lane unlocked and the fine offset is 0, a new pass starts with offset 2^(FINE_W-1) (16 by default). Histories are cleared and locked lanes keep their lock.
- R8: Each further failed pass halves the fine offset, giving 16, 8, 4, 2, 1. After the pass at offset 1 fails, `fail` is set with `done` low. `done` is set with `fail` low once every lane is locked.
- R9: Reset leaves `burst_req`, `done`, `fail` and `lock_mask` at zero. A start clears all locks, `done` and `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when not searching |
| exp_lat | input | LAT_W | Expected strobe return latency in clocks |
| burst_req | output | 1 | Read burst request |
| burst_ack | input | 1 | Burst acknowledge, qualifies `dqs_smp` |
| dqs_smp | input | NLANE | Sampled strobe level, one bit per lane |
| lane_tap | output | NLANE*TAP_W | Coarse tap per lane, lane i at [i*TAP_W +: TAP_W] |
| lane_lat | output | NLANE*LAT_W | Read-enable latency per lane |
| lane_fine | output | NLANE*FINE_W | Fine offset per lane |
| lock_mask | output | NLANE | Per-lane lock flags |
| done | output | 1 | All lanes locked |
| fail | output | 1 | Search exhausted with some lane unlocked |

## Verification
The stub strobe puts an X whose only deviation is in the 32nd sample on every lane's path. A classifier that checks too few samples would see a clean low there and never lock. Non-acknowledged cycles carry inverted strobe values, so a design that samples without acknowledge corrupts every level. Lanes lock at different taps and latencies, up to the last tap of the last latency, and the bench checks that early locks stay frozen and that the group count matches. One lane only matches with a fine offset, and another never matches. These two cases expose a wrong first offset, a wrong halving order, a missing fail flag, or a pass count that is off by one.

// File: rtl/dqs_gate_cal_pkg.sv
package dqs_gate_cal_pkg;
  localparam int HIST_LEN = 9;
  localparam logic [1:0] LV_LO   = 2'b00;
  localparam logic [1:0] LV_HI   = 2'b01;
  localparam logic [1:0] LV_X    = 2'b10;
  localparam logic [1:0] LV_NONE = 2'b11;
  // third-edge signature, oldest entry in the top bits
  localparam logic [2*HIST_LEN-1:0] EDGE3_SIG =
    {LV_LO, LV_LO, LV_LO, LV_X, LV_HI, LV_X, LV_LO, LV_X, LV_HI};
  localparam logic [2*HIST_LEN-1:0] HIST_EMPTY = {HIST_LEN{LV_NONE}};
  typedef enum logic [2:0] {
    ST_IDLE, ST_SMP, ST_EVAL, ST_STEP, ST_DONE, ST_FAIL
  } seq_state_t;
endpackage

// File: rtl/dgc_seq.sv
module dgc_seq
  import dqs_gate_cal_pkg::*;
#(
  parameter int NTAP   = 16,
  parameter int NRDEN  = 4,
  parameter int NBURST = 32,
  parameter int FINE_W = 5,
  parameter int LAT_W  = 6,
  localparam int TAP_W = $clog2(NTAP),
  localparam int RD_W  = (NRDEN > 1) ? $clog2(NRDEN) : 1,
  localparam int CNT_W = $clog2(NBURST)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LAT_W-1:0]  exp_lat,
  input  logic              all_locked,
  input  logic              burst_ack,
  output logic              burst_req,
  output logic              smp_en,
  output logic              grp_end,
  output logic              cal_start,
  output logic              pass_clr,
  output logic [TAP_W-1:0]  tap_q,
  output logic [LAT_W-1:0]  lat_q,
  output logic [FINE_W-1:0] fine_q,
  output logic              done,
  output logic              fail
);
  localparam logic [TAP_W-1:0]  TAP_LAST  = TAP_W'(NTAP - 1);
  localparam logic [RD_W-1:0]   RD_LAST   = RD_W'(NRDEN - 1);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(NBURST - 1);
  localparam logic [FINE_W-1:0] FINE_HALF = {1'b1, {(FINE_W-1){1'b0}}};
  localparam logic [FINE_W-1:0] FINE_ONE  = FINE_W'(1);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt_q;
  logic [RD_W-1:0]   rd_q;
  logic [LAT_W-1:0]  lat_base_q;
  logic              idle, pass_end;

  assign idle      = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL);
  assign cal_start = start && idle;
  assign burst_req = (state == ST_SMP);
  assign smp_en    = (state == ST_SMP) && burst_ack;
  assign grp_end   = (state == ST_EVAL);
  assign pass_end  = (state == ST_STEP) && !all_locked &&
                     (tap_q == TAP_LAST) && (rd_q == RD_LAST);
  assign pass_clr  = pass_end && (fine_q != FINE_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt_q      <= '0;
      tap_q      <= '0;
      rd_q       <= '0;
      lat_q      <= '0;
      lat_base_q <= '0;
      fine_q     <= '0;
      done       <= 1'b0;
      fail       <= 1'b0;
    end else if (cal_start) begin
      state      <= ST_SMP;
      cnt_q      <= '0;
      tap_q      <= '0;
      rd_q       <= '0;
      lat_q      <= exp_lat - LAT_W'(2);
      lat_base_q <= exp_lat - LAT_W'(2);
      fine_q     <= '0;
      done       <= 1'b0;
      fail       <= 1'b0;
    end else begin
      case (state)
        ST_SMP: if (burst_ack) begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_LAST) state <= ST_EVAL;
        end
        ST_EVAL: state <= ST_STEP;
        ST_STEP: begin
          cnt_q <= '0;
          if (all_locked) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end else if (tap_q != TAP_LAST) begin
            tap_q <= tap_q + TAP_W'(1);
            state <= ST_SMP;
          end else if (rd_q != RD_LAST) begin
            tap_q <= '0;
            rd_q  <= rd_q + RD_W'(1);
            lat_q <= lat_q + LAT_W'(1);
            state <= ST_SMP;
          end else if (fine_q == FINE_ONE) begin
            state <= ST_FAIL;
            fail  <= 1'b1;
          end else begin
            tap_q  <= '0;
            rd_q   <= '0;
            lat_q  <= lat_base_q;
            fine_q <= (fine_q == '0) ? FINE_HALF : (fine_q >> 1);
            state  <= ST_SMP;
          end
        end
        default: ;
      endcase
    end
  end

  p_tap_fixed_in_group_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SMP && $past(state == ST_SMP)) |-> ($stable(tap_q) && $stable(lat_q)));
  p_fine_halves_r8: assert property (@(posedge clk) disable iff (rst)
    (fine_q != '0 && $past(fine_q) != '0 && fine_q != $past(fine_q))
      |-> (fine_q == ($past(fine_q) >> 1)));
  p_done_fail_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
  p_no_req_when_finished_r2: assert property (@(posedge clk) disable iff (rst)
    burst_req |-> (!done && !fail));
endmodule

// File: rtl/dgc_lane.sv
module dgc_lane
  import dqs_gate_cal_pkg::*;
#(
  parameter int TAP_W  = 4,
  parameter int LAT_W  = 6,
  parameter int FINE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_start,
  input  logic              pass_clr,
  input  logic              smp_en,
  input  logic              smp,
  input  logic              grp_end,
  input  logic [TAP_W-1:0]  cur_tap,
  input  logic [LAT_W-1:0]  cur_lat,
  input  logic [FINE_W-1:0] cur_fine,
  output logic              locked,
  output logic [TAP_W-1:0]  tap_o,
  output logic [LAT_W-1:0]  lat_o,
  output logic [FINE_W-1:0] fine_o
);
  localparam int HW = 2 * HIST_LEN;

  logic [HW-1:0]     hist_q, hist_nx;
  logic              first_q, have_q, diff_q;
  logic [1:0]        lvl;
  logic [TAP_W-1:0]  frz_tap;
  logic [LAT_W-1:0]  frz_lat;
  logic [FINE_W-1:0] frz_fine;

  assign lvl     = diff_q ? LV_X : (first_q ? LV_HI : LV_LO);
  assign hist_nx = {hist_q[HW-3:0], lvl};

  always_ff @(posedge clk) begin
    if (rst || cal_start) begin
      hist_q   <= HIST_EMPTY;
      first_q  <= 1'b0;
      have_q   <= 1'b0;
      diff_q   <= 1'b0;
      locked   <= 1'b0;
      frz_tap  <= '0;
      frz_lat  <= '0;
      frz_fine <= '0;
    end else begin
      if (pass_clr) hist_q <= HIST_EMPTY;
      if (smp_en) begin
        if (!have_q) begin
          first_q <= smp;
          have_q  <= 1'b1;
          diff_q  <= 1'b0;
        end else if (smp != first_q) begin
          diff_q <= 1'b1;
        end
      end
      if (grp_end) begin
        hist_q <= hist_nx;
        have_q <= 1'b0;
        if (!locked && hist_nx == EDGE3_SIG) begin
          locked   <= 1'b1;
          frz_tap  <= cur_tap;
          frz_lat  <= cur_lat;
          frz_fine <= cur_fine;
        end
      end
    end
  end

  assign tap_o  = locked ? frz_tap  : cur_tap;
  assign lat_o  = locked ? frz_lat  : cur_lat;
  assign fine_o = locked ? frz_fine : cur_fine;

  p_lock_on_sig_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (hist_q == EDGE3_SIG));
  p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> ($stable(tap_o) && $stable(lat_o) && $stable(fine_o)));
endmodule

// File: rtl/dqs_gate_cal.sv
module dqs_gate_cal
  import dqs_gate_cal_pkg::*;
#(
  parameter int NLANE  = 8,
  parameter int NTAP   = 16,
  parameter int NRDEN  = 4,
  parameter int NBURST = 32,
  parameter int FINE_W = 5,
  parameter int LAT_W  = 6,
  localparam int TAP_W = $clog2(NTAP)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [LAT_W-1:0]        exp_lat,
  output logic                    burst_req,
  input  logic                    burst_ack,
  input  logic [NLANE-1:0]        dqs_smp,
  output logic [NLANE*TAP_W-1:0]  lane_tap,
  output logic [NLANE*LAT_W-1:0]  lane_lat,
  output logic [NLANE*FINE_W-1:0] lane_fine,
  output logic [NLANE-1:0]        lock_mask,
  output logic                    done,
  output logic                    fail
);
  logic              smp_en, grp_end, cal_start, pass_clr;
  logic [TAP_W-1:0]  tap_q;
  logic [LAT_W-1:0]  lat_q;
  logic [FINE_W-1:0] fine_q;

  dgc_seq #(.NTAP(NTAP), .NRDEN(NRDEN), .NBURST(NBURST),
            .FINE_W(FINE_W), .LAT_W(LAT_W)) seq_i (
    .clk(clk), .rst(rst), .start(start), .exp_lat(exp_lat),
    .all_locked(&lock_mask), .burst_ack(burst_ack), .burst_req(burst_req),
    .smp_en(smp_en), .grp_end(grp_end), .cal_start(cal_start),
    .pass_clr(pass_clr), .tap_q(tap_q), .lat_q(lat_q), .fine_q(fine_q),
    .done(done), .fail(fail)
  );

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    dgc_lane #(.TAP_W(TAP_W), .LAT_W(LAT_W), .FINE_W(FINE_W)) lane_i (
      .clk(clk), .rst(rst), .cal_start(cal_start), .pass_clr(pass_clr),
      .smp_en(smp_en), .smp(dqs_smp[i]), .grp_end(grp_end),
      .cur_tap(tap_q), .cur_lat(lat_q), .cur_fine(fine_q),
      .locked(lock_mask[i]),
      .tap_o(lane_tap[i*TAP_W +: TAP_W]),
      .lat_o(lane_lat[i*LAT_W +: LAT_W]),
      .fine_o(lane_fine[i*FINE_W +: FINE_W])
    );
  end

  p_done_all_locked_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (&lock_mask));
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(start) |-> ((lock_mask & $past(lock_mask)) == $past(lock_mask)));
endmodule

// File: tb/dqs_gate_cal_tb_top.sv
`timescale 1ns/1ps
module dqs_gate_cal_tb_top;
  localparam int NLANE = 8, NTAP = 16, NRDEN = 4, NBURST = 32, FINE_W = 5, LAT_W = 6;
  localparam int TAP_W = $clog2(NTAP);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, burst_ack = 1'b0;
  logic [LAT_W-1:0] exp_lat = '0;
  logic burst_req, done, fail;
  logic [NLANE-1:0] dqs_smp = '0, lock_mask;
  logic [NLANE*TAP_W-1:0]  lane_tap;
  logic [NLANE*LAT_W-1:0]  lane_lat;
  logic [NLANE*FINE_W-1:0] lane_fine;

  always #10 clk = ~clk;

  dqs_gate_cal #(.NLANE(NLANE), .NTAP(NTAP), .NRDEN(NRDEN), .NBURST(NBURST),
                 .FINE_W(FINE_W), .LAT_W(LAT_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .exp_lat(exp_lat),
    .burst_req(burst_req), .burst_ack(burst_ack), .dqs_smp(dqs_smp),
    .lane_tap(lane_tap), .lane_lat(lane_lat), .lane_fine(lane_fine),
    .lock_mask(lock_mask), .done(done), .fail(fail));

  int nchk = 0, nerr = 0;
  int off[NLANE];
  int dcd_lane = -1, bad_lane = -1, exp_int = 12;
  int grp = 0, bidx = 0, cyc = 0;
  int fseq[16];
  int fseq_n = 0, last_fine0 = 0;
  logic req_prev = 1'b0;
  int base_seq[9] = '{0, 0, 0, 3, 1, 2, 0, 2, 1}; // 0 lo,1 hi,2 X alternating,3 X in last burst only

  task automatic chk(int act, int expv, string what);
    nchk++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", what, act, expv);
    end
  endtask

  function automatic int ltap(int l);  return int'(lane_tap[l*TAP_W +: TAP_W]);    endfunction
  function automatic int llat(int l);  return int'(lane_lat[l*LAT_W +: LAT_W]);    endfunction
  function automatic int lfine(int l); return int'(lane_fine[l*FINE_W +: FINE_W]); endfunction

  function automatic logic strobe(int l, int b);
    int pos, k, e;
    pos = (llat(l) - (exp_int - 2)) * NTAP + ltap(l);
    k = pos - off[l];
    if (k < 0) e = 0;
    else if (k > 8) e = 2;
    else e = base_seq[k];
    if (l == dcd_lane && lfine(l) == 0 && k == 5) e = 1;
    if (l == bad_lane && k == 7) e = 0;
    case (e)
      0: return 1'b0;
      1: return 1'b1;
      2: return b[0];
      default: return (b == NBURST - 1);
    endcase
  endfunction

  // DRAM/PHY stub: acknowledges two cycles in three, drives garbage otherwise
  initial forever begin
    @(negedge clk);
    cyc++;
    if (burst_req && !req_prev) grp++;
    req_prev = burst_req;
    if (lfine(0) != last_fine0 && fseq_n < 16) begin
      fseq[fseq_n] = lfine(0);
      fseq_n++;
      last_fine0 = lfine(0);
    end
    if (!burst_req) bidx = 0;
    if (burst_req && (cyc % 3 != 1)) begin
      burst_ack = 1'b1;
      for (int l = 0; l < NLANE; l++) dqs_smp[l] = strobe(l, bidx);
      bidx++;
    end else begin
      burst_ack = 1'b0;
      for (int l = 0; l < NLANE; l++) dqs_smp[l] = ~strobe(l, bidx);
    end
  end

  task automatic kick(int e);
    exp_int = e;
    exp_lat = LAT_W'(e);
    @(negedge clk);
    grp = 0; fseq_n = 1; fseq[0] = 0; last_fine0 = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(llat(0), e - 2, "R1 first latency");
    chk(ltap(0), 0, "R1 first tap");
    chk(lfine(0), 0, "R1 first fine");
    chk(int'(burst_req), 1, "R2 request after start");
    for (int w = 0; w < 60000 && !done && !fail; w++) @(negedge clk);
    if (!done && !fail) begin
      nerr++;
      $display("FAIL watchdog: search did not finish");
    end
  endtask

  task automatic t_reset();
    chk(int'(burst_req), 0, "R9 reset req");
    chk(int'(done), 0, "R9 reset done");
    chk(int'(fail), 0, "R9 reset fail");
    chk(int'(lock_mask), 0, "R9 reset lock mask");
  endtask

  task automatic t_basic();
    off = '{0, 3, 7, 12, 20, 25, 40, 55};
    dcd_lane = -1; bad_lane = -1;
    kick(12);
    chk(int'(done), 1, "R8 done all locked");
    chk(int'(fail), 0, "R8 no fail");
    chk(int'(lock_mask), 255, "R5 lock mask");
    chk(grp, 64, "R4 groups until last lane locks");
    for (int l = 0; l < NLANE; l++) begin
      chk(ltap(l), (off[l] + 8) % NTAP, $sformatf("R5 lane %0d tap", l));
      chk(llat(l), 10 + (off[l] + 8) / NTAP, $sformatf("R4 lane %0d latency", l));
      chk(lfine(l), 0, $sformatf("R6 lane %0d fine", l));
    end
    chk(int'(burst_req), 0, "R2 no request after done");
  endtask

  task automatic t_fine_offset();
    off = '{2, 5, 9, 12, 18, 30, 33, 47};
    dcd_lane = 3; bad_lane = -1;
    kick(20);
    chk(int'(done), 1, "R7 done after fine retry");
    chk(int'(lock_mask), 255, "R7 lock mask");
    chk(grp, 64 + 21, "R7 groups across two passes");
    chk(lfine(3), 16, "R7 retry lane fine offset");
    chk(ltap(3), 4, "R7 retry lane tap");
    chk(llat(3), 19, "R7 retry lane latency");
    chk(lfine(7), 0, "R6 first-pass lane keeps fine 0");
    chk(ltap(7), 7, "R6 first-pass lane keeps tap");
    chk(llat(7), 21, "R6 first-pass lane keeps latency");
  endtask

  task automatic t_fail();
    off = '{0, 1, 4, 8, 16, 31, 44, 50};
    dcd_lane = -1; bad_lane = 0;
    kick(8);
    chk(int'(fail), 1, "R8 fail flag");
    chk(int'(done), 0, "R8 done low on fail");
    chk(int'(lock_mask), 254, "R6 lock mask with one bad lane");
    chk(grp, 6 * 64, "R8 six passes");
    chk(fseq_n, 6, "R8 fine step count");
    chk(fseq[1], 16, "R7 first offset");
    chk(fseq[2], 8, "R8 offset 8");
    chk(fseq[3], 4, "R8 offset 4");
    chk(fseq[4], 2, "R8 offset 2");
    chk(fseq[5], 1, "R8 offset 1");
    chk(ltap(7), (50 + 8) % NTAP, "R6 lane 7 tap kept");
    chk(llat(7), 6 + (50 + 8) / NTAP, "R6 lane 7 latency kept");
    // X with only the 32nd sample different must not read as low (R3)
    chk(ltap(1), 9, "R3 last-burst X classified");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_fine_offset();
    t_fail();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run exceeded cycle limit");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule